// File: doc/BRIEF.md
# Shared-Memory Ring Buffer Agent

This block services byte ring buffers that live in the RAM of a neighbouring processor. It never owns that memory. It borrows the processor's bus through a request/grant pair, performs a few single-byte memory cycles, and hands the bus back. Each buffer is known by a base address. Three control bytes sit just below the base: the length-minus-one mask, the producer index and the consumer index. The agent keeps a per-channel descriptor holding the base, the mask and local copies of both indices. A small channel number picks the descriptor.

A requester issues one command at a time. The commands are: load a channel's descriptor from remote memory, test for empty, test for full, take one byte, and deposit one byte. Tests and loads finish with a one-cycle done pulse that carries a result flag. A take returns its byte on a valid/ready pair. A take on an empty buffer, or a deposit into a full one, polls the peer's index. Each poll is its own bus tenure, so the processor can run between polls and move the index. A take or deposit on a channel whose base is zero waits without touching the bus.

Top module: `rba_agent`

## Requirements
- R1: After reset the agent is ready for a command, and busReq, getValid and doneValid are all low.
- R2: On a channel whose base is zero, both the empty test and the full test report flag 1 without requesting the bus.
- R3: Load (cmdOp 0) stores cmdAddr as the channel base, then reads base-3, base-2 and base-1, in that order, into the mask, the producer index and the consumer index. Each channel keeps its own descriptor.
- R4: The empty test (cmdOp 1) reads the producer index at base-2. Its flag is 1 exactly when that byte equals the local consumer index.
- R5: The full test (cmdOp 2) reads the consumer index at base-1. Its flag is 1 exactly when ((local producer + 1) AND mask) equals that byte.
- R6: Take (cmdOp 3) reads the byte at base+consumer and writes the advanced consumer index to base-1. It then holds getValid and getData steady until getReady.
- R7: Deposit (cmdOp 4) writes cmdData at base+producer and then writes the advanced producer index to base-2.
- R8: Both indices advance by one and wrap through AND with the channel mask.
- R9: Each test is exactly one bus tenure. Memory cycles occur only while busAck is high, and each is held until memDone. The bus is released only after a completed access.
- R10: A take on an empty buffer, or a deposit into a full one, polls again in a fresh bus tenure. The bus is released between polls. The command finishes once the peer moves its index.
- R11: No new command is accepted while take data waits for getReady.
- R12: doneValid is a one-cycle pulse, given only with the bus released. Its flag is 0 for load and deposit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command offered |
| cmdReady | output | 1 | Agent idle, command taken this cycle if valid |
| cmdOp | input | 3 | 0 load, 1 empty test, 2 full test, 3 take, 4 deposit |
| cmdChan | input | CH_W | Channel select |
| cmdAddr | input | ADDR_W | Base address, used by load |
| cmdData | input | DATA_W | Byte to deposit |
| doneValid | output | 1 | One-cycle completion of load, test or deposit |
| doneFlag | output | 1 | Test result |
| getValid | output | 1 | Take data available |
| getReady | input | 1 | Take data consumed |
| getData | output | DATA_W | Byte taken |
| busReq | output | 1 | Bus borrow request |
| busAck | input | 1 | Bus granted |
| memValid | output | 1 | Memory cycle active |
| memWrite | output | 1 | Memory cycle is a write |
| memAddr | output | ADDR_W | Memory cycle address |
| memWdata | output | DATA_W | Write byte |
| memRdata | input | DATA_W | Read byte, valid with memDone |
| memDone | input | 1 | Memory cycle complete |

## Verification
A take result waiting on getReady and a new command offer can occur in the same cycle. The bench holds getReady low while it offers an empty test. For several cycles it checks that cmdReady stays low and that getValid and getData stay frozen. It then checks that the test is taken right after the handshake and reports the state left by the take. A second overlap is a peer index update landing between two polls of a blocked take or deposit. The bench writes remote memory only in a cycle where both busReq and busAck are low, then checks that the blocked command completes with the new data and indices.

// File: rtl/rba_pkg.sv
package rba_pkg;

  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_PUT   = 3'd4
  } rbaOp_e;

  // control -> datapath strobes
  typedef struct packed {
    logic       accept;   // command taken this cycle
    logic       capture;  // memory cycle completing this cycle
    logic       xfer;     // transfer phase (not poll)
    logic [1:0] step;     // access index inside the tenure
    rbaOp_e     op;       // active opcode
  } rbaStrobe_t;

endpackage

// File: rtl/rba_ctrl.sv
module rba_ctrl
  import rba_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [2:0] cmdOp,
  output logic       cmdReady,
  output logic       busReq,
  input  logic       busAck,
  output logic       memValid,
  input  logic       memDone,
  output logic       getValid,
  input  logic       getReady,
  output logic       doneValid,
  input  logic       zeroBase,
  input  logic       pollBusy,
  output rbaStrobe_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_ACQ, S_ACC, S_REL, S_CHECK, S_HOLD, S_FIN
  } state_e;

  state_e     stateQ, stateD;
  rbaOp_e     opQ;
  logic       xferQ, xferD;
  logic [1:0] stepQ, stepD;
  logic [1:0] lastStep;
  logic       isTest, isMove;

  assign isTest   = (opQ == OP_EMPTY) || (opQ == OP_FULL);
  assign isMove   = (opQ == OP_GET) || (opQ == OP_PUT);
  assign lastStep = (opQ == OP_INIT) ? 2'd2 : (xferQ ? 2'd1 : 2'd0);

  always_comb begin
    stateD = stateQ;
    xferD  = xferQ;
    stepD  = stepQ;
    unique case (stateQ)
      S_IDLE: if (cmdValid) begin
        stateD = S_START;
        xferD  = 1'b0;
        stepD  = 2'd0;
      end
      S_START: begin
        if (!isTest && !isMove && opQ != OP_INIT) stateD = S_FIN;
        else if (zeroBase && opQ != OP_INIT) begin
          if (isTest) stateD = S_FIN;
        end else stateD = S_ACQ;
      end
      S_ACQ: if (busAck) stateD = S_ACC;
      S_ACC: if (memDone) begin
        if (stepQ == lastStep) begin
          stepD  = 2'd0;
          stateD = S_REL;
        end else stepD = stepQ + 2'd1;
      end
      S_REL: if (!busAck) stateD = S_CHECK;
      S_CHECK: begin
        if (isMove && !xferQ) begin
          if (!pollBusy) xferD = 1'b1;
          stateD = S_ACQ;
        end else if (opQ == OP_GET) stateD = S_HOLD;
        else stateD = S_FIN;
      end
      S_HOLD: if (getReady) stateD = S_IDLE;
      S_FIN:  stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      opQ    <= OP_INIT;
      xferQ  <= 1'b0;
      stepQ  <= 2'd0;
    end else begin
      stateQ <= stateD;
      xferQ  <= xferD;
      stepQ  <= stepD;
      if (stateQ == S_IDLE && cmdValid) opQ <= rbaOp_e'(cmdOp);
    end
  end

  assign cmdReady  = (stateQ == S_IDLE);
  assign busReq    = (stateQ == S_ACQ) || (stateQ == S_ACC);
  assign memValid  = (stateQ == S_ACC);
  assign getValid  = (stateQ == S_HOLD);
  assign doneValid = (stateQ == S_FIN);

  assign strb.accept  = cmdReady && cmdValid;
  assign strb.capture = memValid && memDone;
  assign strb.xfer    = xferQ;
  assign strb.step    = stepQ;
  assign strb.op      = cmdReady ? rbaOp_e'(cmdOp) : opQ;

  // R9
  grant_before_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid |-> busAck);
  // R9
  access_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memValid && !memDone |=> memValid);
  // R9
  release_after_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busReq) |-> $past(memDone));
  // R12
  done_bus_free_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> !busAck && !busReq);

endmodule

// File: rtl/rba_dpath.sv
module rba_dpath
  import rba_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rbaStrobe_t        strb,
  input  logic [CH_W-1:0]   cmdChan,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWrite,
  output logic [DATA_W-1:0] memWdata,
  output logic              zeroBase,
  output logic              pollBusy,
  output logic              testFlag,
  output logic [DATA_W-1:0] getData
);

  localparam logic [ADDR_W-1:0] OFS_MASK = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] OFS_PROD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFS_CONS = ADDR_W'(1);

  logic [ADDR_W-1:0] baseArr [NUM_CH];
  logic [DATA_W-1:0] maskArr [NUM_CH];
  logic [DATA_W-1:0] prodArr [NUM_CH];
  logic [DATA_W-1:0] consArr [NUM_CH];

  logic [CH_W-1:0]   chanQ;
  logic [DATA_W-1:0] putQ, pollQ, getQ;
  logic [ADDR_W-1:0] curBase;
  logic [DATA_W-1:0] curMask, curProd, curCons, nextProd, nextCons;
  logic              capMask, capProd, capCons, advProd, advCons, capPoll, capGet;
  logic              emptyNow, fullNow;

  assign curBase  = baseArr[chanQ];
  assign curMask  = maskArr[chanQ];
  assign curProd  = prodArr[chanQ];
  assign curCons  = consArr[chanQ];
  assign nextProd = (curProd + DATA_W'(1)) & curMask;
  assign nextCons = (curCons + DATA_W'(1)) & curMask;

  // capture decode
  always_comb begin
    capMask = strb.capture && strb.op == OP_INIT && strb.step == 2'd0;
    capProd = strb.capture && strb.op == OP_INIT && strb.step == 2'd1;
    capCons = strb.capture && strb.op == OP_INIT && strb.step == 2'd2;
    advCons = strb.capture && strb.op == OP_GET && strb.xfer && strb.step == 2'd1;
    advProd = strb.capture && strb.op == OP_PUT && strb.xfer && strb.step == 2'd1;
    capGet  = strb.capture && strb.op == OP_GET && strb.xfer && strb.step == 2'd0;
    capPoll = strb.capture && !strb.xfer && strb.op != OP_INIT;
  end

  // per-channel descriptors
  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    logic [ADDR_W-1:0] baseR;
    logic [DATA_W-1:0] maskR, prodR, consR;
    logic              selHit, wrBase;

    assign selHit = (chanQ == CH_W'(g));
    assign wrBase = strb.accept && strb.op == OP_INIT && cmdChan == CH_W'(g);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseR <= '0;
        maskR <= '0;
        prodR <= '0;
        consR <= '0;
      end else begin
        if (wrBase) baseR <= cmdAddr;
        if (selHit && capMask) maskR <= memRdata;
        if (selHit && capProd) prodR <= memRdata;
        else if (selHit && advProd) prodR <= nextProd;
        if (selHit && capCons) consR <= memRdata;
        else if (selHit && advCons) consR <= nextCons;
      end
    end

    assign baseArr[g] = baseR;
    assign maskArr[g] = maskR;
    assign prodArr[g] = prodR;
    assign consArr[g] = consR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chanQ <= '0;
      putQ  <= '0;
      pollQ <= '0;
      getQ  <= '0;
    end else begin
      if (strb.accept) begin
        chanQ <= cmdChan;
        putQ  <= cmdData;
      end
      if (capPoll) pollQ <= memRdata;
      if (capGet)  getQ  <= memRdata;
    end
  end

  // address and write data for the current access
  always_comb begin
    memAddr  = curBase;
    memWrite = 1'b0;
    memWdata = '0;
    unique case (strb.op)
      OP_INIT:  memAddr = curBase - (OFS_MASK - ADDR_W'(strb.step));
      OP_EMPTY: memAddr = curBase - OFS_PROD;
      OP_FULL:  memAddr = curBase - OFS_CONS;
      OP_GET: begin
        if (!strb.xfer) memAddr = curBase - OFS_PROD;
        else if (strb.step == 2'd0) memAddr = curBase + ADDR_W'(curCons);
        else begin
          memAddr  = curBase - OFS_CONS;
          memWrite = 1'b1;
          memWdata = nextCons;
        end
      end
      OP_PUT: begin
        if (!strb.xfer) memAddr = curBase - OFS_CONS;
        else if (strb.step == 2'd0) begin
          memAddr  = curBase + ADDR_W'(curProd);
          memWrite = 1'b1;
          memWdata = putQ;
        end else begin
          memAddr  = curBase - OFS_PROD;
          memWrite = 1'b1;
          memWdata = nextProd;
        end
      end
      default: memAddr = curBase;
    endcase
  end

  assign zeroBase = (curBase == '0);
  assign emptyNow = (pollQ == curCons);
  assign fullNow  = (nextProd == pollQ);
  assign pollBusy = (strb.op == OP_GET) ? emptyNow : fullNow;
  assign testFlag = (strb.op == OP_EMPTY && (zeroBase || emptyNow)) ||
                    (strb.op == OP_FULL  && (zeroBase || fullNow));
  assign getData  = getQ;

endmodule

// File: rtl/rba_agent.sv
module rba_agent
  import rba_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NUM_CH = 4,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [CH_W-1:0]   cmdChan,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [DATA_W-1:0] cmdData,
  output logic              doneValid,
  output logic              doneFlag,
  output logic              getValid,
  input  logic              getReady,
  output logic [DATA_W-1:0] getData,
  output logic              busReq,
  input  logic              busAck,
  output logic              memValid,
  output logic              memWrite,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memDone
);

  rbaStrobe_t strb;
  logic       zeroBase, pollBusy;

  rba_ctrl uCtrl (
    .clk, .rstN, .cmdValid, .cmdOp, .cmdReady, .busReq, .busAck,
    .memValid, .memDone, .getValid, .getReady, .doneValid,
    .zeroBase, .pollBusy, .strb
  );

  rba_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CH(NUM_CH)) uDpath (
    .clk, .rstN, .strb, .cmdChan, .cmdAddr, .cmdData, .memRdata,
    .memAddr, .memWrite, .memWdata, .zeroBase, .pollBusy,
    .testFlag(doneFlag), .getData
  );

  // R6
  get_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    getValid && !getReady |=> getValid && $stable(getData));

endmodule

// File: tb/rba_agent_test.sv
`timescale 1ns/1ps
module rba_agent_test;
  localparam int AW = 16;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic          cmdReady;
  logic [2:0]    cmdOp = '0;
  logic [CW-1:0] cmdChan = '0;
  logic [AW-1:0] cmdAddr = '0;
  logic [7:0]    cmdData = '0;
  logic          doneValid, doneFlag, getValid;
  logic          getReady = 1'b0;
  logic [7:0]    getData;
  logic          busReq, memValid, memWrite;
  logic          busAck = 1'b0;
  logic [AW-1:0] memAddr;
  logic [7:0]    memWdata;
  logic [7:0]    memRdata = '0;
  logic          memDone = 1'b0;

  logic [7:0]    mem [256];
  logic [AW-1:0] logA [64];
  logic          logW [64];
  int            logN = 0;
  int            tenures = 0;
  logic          prevReq = 1'b0;
  int            errors = 0;
  int            checks = 0;
  int            mBase [4];
  int            mMask [4];
  int            mProd [4];
  int            mCons [4];

  always #2.5 clk = ~clk;

  rba_agent uut (
    .clk, .rstN, .cmdValid, .cmdReady, .cmdOp, .cmdChan, .cmdAddr, .cmdData,
    .doneValid, .doneFlag, .getValid, .getReady, .getData,
    .busReq, .busAck, .memValid, .memWrite, .memAddr, .memWdata,
    .memRdata, .memDone
  );

  // remote bus and memory responder, acting at negedges
  initial begin
    forever begin
      @(negedge clk);
      if (busReq && !prevReq) tenures++;
      prevReq = busReq;
      busAck = busReq;
      if (memValid && !memDone) begin
        memDone = 1'b1;
        logA[logN % 64] = memAddr;
        logW[logN % 64] = memWrite;
        logN++;
        if (memWrite) mem[memAddr[7:0]] = memWdata;
        else memRdata = mem[memAddr[7:0]];
      end else memDone = 1'b0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input int op, input int ch, input int adr, input int dat);
    @(negedge clk);
    cmdValid = 1'b1;
    cmdOp    = 3'(op);
    cmdChan  = CW'(ch);
    cmdAddr  = AW'(adr);
    cmdData  = 8'(dat);
    while (!cmdReady) @(negedge clk);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic waitDone(output bit flag, input string req);
    int n = 0;
    flag = 1'b0;
    while (!doneValid && n < 3000) begin @(negedge clk); n++; end
    if (!doneValid) chk(1'b0, req, 0, 1);
    else begin
      flag = doneFlag;
      @(negedge clk);
      chk(!doneValid, "R12 done pulse width", int'(doneValid), 0);
    end
  endtask

  task automatic waitGet(output logic [7:0] d, input string req);
    int n = 0;
    d = '0;
    while (!getValid && n < 3000) begin @(negedge clk); n++; end
    if (!getValid) chk(1'b0, req, 0, 1);
    else begin
      d = getData;
      getReady = 1'b1;
      @(negedge clk);
      getReady = 1'b0;
    end
  endtask

  task automatic doTest(input int op, input int ch, input bit exp, input string req);
    bit f;
    issue(op, ch, 0, 0);
    waitDone(f, req);
    chk(f == exp, req, int'(f), int'(exp));
  endtask

  task automatic doPut(input int ch, input int b);
    bit f;
    int np;
    issue(4, ch, 0, b);
    waitDone(f, "R7 put done");
    np = (mProd[ch] + 1) & mMask[ch];
    chk(f == 1'b0, "R12 put flag", int'(f), 0);
    chk(mem[8'(mBase[ch] + mProd[ch])] == 8'(b), "R7 put data slot",
        int'(mem[8'(mBase[ch] + mProd[ch])]), b);
    chk(mem[8'(mBase[ch] - 2)] == 8'(np), "R8 R7 producer write-back",
        int'(mem[8'(mBase[ch] - 2)]), np);
    mProd[ch] = np;
  endtask

  task automatic doGet(input int ch, input int exp);
    logic [7:0] d;
    int nc;
    issue(3, ch, 0, 0);
    waitGet(d, "R6 get result");
    nc = (mCons[ch] + 1) & mMask[ch];
    chk(d == 8'(exp), "R6 get data", int'(d), exp);
    chk(mem[8'(mBase[ch] - 1)] == 8'(nc), "R8 R6 consumer write-back",
        int'(mem[8'(mBase[ch] - 1)]), nc);
    mCons[ch] = nc;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    bit f;
    int t0, l0, nPre, pIdx;
    logic [7:0] d0, d1;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h55);
    for (int i = 0; i < 4; i++) begin
      mBase[i] = 0; mMask[i] = 0; mProd[i] = 0; mCons[i] = 0;
    end

    // R1 reset state
    repeat (4) @(negedge clk);
    chk(cmdReady == 1'b1, "R1 cmdReady", int'(cmdReady), 1);
    chk(busReq == 1'b0, "R1 busReq", int'(busReq), 0);
    chk(getValid == 1'b0 && doneValid == 1'b0, "R1 outputs idle",
        int'({getValid, doneValid}), 0);
    rstN = 1'b1;

    // R2 zero-base channel
    t0 = tenures;
    doTest(1, 3, 1'b1, "R2 empty on zero base");
    doTest(2, 3, 1'b1, "R2 full on zero base");
    chk(tenures == t0, "R2 no bus use", tenures, t0);

    // R3 load channel 1: base 0x20, length 4
    mem[8'h1D] = 8'd3; mem[8'h1E] = 8'd0; mem[8'h1F] = 8'd0;
    mBase[1] = 32'h20; mMask[1] = 3;
    l0 = logN;
    issue(0, 1, 32'h20, 0);
    waitDone(f, "R3 load done");
    chk(f == 1'b0, "R12 load flag", int'(f), 0);
    chk(logN - l0 == 3, "R3 access count", logN - l0, 3);
    for (int k = 0; k < 3; k++)
      chk(logA[(l0 + k) % 64] == AW'(32'h1D + k) && !logW[(l0 + k) % 64],
          "R3 load read order", int'(logA[(l0 + k) % 64]), 32'h1D + k);

    // R4 R5 R9 tests on fresh buffer
    t0 = tenures;
    doTest(1, 1, 1'b1, "R4 empty on fresh buffer");
    doTest(2, 1, 1'b0, "R5 full on fresh buffer");
    chk(tenures == t0 + 2, "R9 one tenure per test", tenures, t0 + 2);

    // R7 fill to capacity
    for (int i = 0; i < 3; i++) doPut(1, 8'hA0 + i);
    doTest(2, 1, 1'b1, "R5 full after three deposits");
    doTest(1, 1, 1'b0, "R4 not empty after deposits");
    for (int i = 0; i < 3; i++) doGet(1, 8'hA0 + i);
    doTest(1, 1, 1'b1, "R4 empty after draining");

    // R8 wrap sweep across all index positions
    for (int r = 0; r < 12; r++) begin
      int k = (r % 3) + 1;
      for (int i = 0; i < k; i++) doPut(1, r * 16 + i);
      for (int i = 0; i < k; i++) doGet(1, (r * 16 + i) & 8'hFF);
    end

    // R11 command offered while take data is held
    doPut(1, 8'h77);
    issue(3, 1, 0, 0);
    nPre = 0;
    while (!getValid && nPre < 3000) begin @(negedge clk); nPre++; end
    d0 = getData;
    chk(d0 == 8'h77, "R6 held take data", int'(d0), 32'h77);
    cmdValid = 1'b1; cmdOp = 3'd1; cmdChan = 2'd1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(cmdReady == 1'b0, "R11 no accept while holding", int'(cmdReady), 0);
      chk(getValid && getData == d0, "R6 hold stable", int'(getData), int'(d0));
    end
    getReady = 1'b1;
    @(negedge clk);
    getReady = 1'b0;
    @(negedge clk);
    cmdValid = 1'b0;
    mCons[1] = (mCons[1] + 1) & mMask[1];
    waitDone(f, "R11 queued test done");
    chk(f == 1'b1, "R11 R4 queued empty test", int'(f), 1);

    // R10 blocked take, peer produces between polls
    t0 = tenures;
    issue(3, 1, 0, 0);
    repeat (60) @(negedge clk);
    chk(getValid == 1'b0, "R10 take blocked", int'(getValid), 0);
    chk(tenures - t0 >= 3, "R10 repeated poll tenures", tenures - t0, 3);
    while (busReq || busAck) @(negedge clk);
    pIdx = mCons[1];
    mem[8'(mBase[1] + pIdx)] = 8'h5A;
    mem[8'(mBase[1] - 2)] = 8'((pIdx + 1) & 3);
    waitGet(d1, "R10 take released");
    chk(d1 == 8'h5A, "R10 take data after peer", int'(d1), 32'h5A);
    chk(mem[8'(mBase[1] - 1)] == 8'((pIdx + 1) & 3), "R10 consumer after peer",
        int'(mem[8'(mBase[1] - 1)]), (pIdx + 1) & 3);

    // R10 blocked deposit on channel 2: base 0x60, length 8
    mem[8'h5D] = 8'd7; mem[8'h5E] = 8'd0; mem[8'h5F] = 8'd0;
    mBase[2] = 32'h60; mMask[2] = 7;
    issue(0, 2, 32'h60, 0);
    waitDone(f, "R3 load channel 2");
    for (int i = 0; i < 7; i++) doPut(2, 8'hC0 + i);
    doTest(2, 2, 1'b1, "R5 channel 2 full");
    doTest(1, 1, 1'b1, "R3 channel 1 unaffected");
    issue(4, 2, 0, 8'hEE);
    repeat (60) @(negedge clk);
    chk(mem[8'h5E] == 8'd7, "R10 deposit blocked", int'(mem[8'h5E]), 7);
    while (busReq || busAck) @(negedge clk);
    mem[8'h5F] = 8'd1;
    waitDone(f, "R10 deposit released");
    chk(mem[8'h67] == 8'hEE, "R10 deposit data", int'(mem[8'h67]), 32'hEE);
    chk(mem[8'h5E] == 8'd0, "R8 producer wraps to zero", int'(mem[8'h5E]), 0);

    summary();
    $finish;
  end
endmodule